// File: doc/BRIEF.md
# Byte-Mapped Seconds Counter RTC

This block keeps the wall-clock time of a chip as a plain count of seconds. The count is 32 bits wide, advances once for every pulse on a one-pulse-per-second input while counting is switched on, and rolls from all ones back to zero. A second 32-bit value holds an alarm time. When a counting tick brings the count to that value and the alarm is armed, a sticky pending flag is set. The flag drives a level output that an interrupt controller can catch on its rising edge.

A host reaches everything through a small byte-wide register bus: an address, write data, a write strobe, a read strobe and registered read data. A new time goes in through a set of staging bytes. Writing the three upper bytes only fills the staging bytes. Writing the lowest byte moves the whole value into the counter in that cycle. The count read port has no snapshot, so each byte read returns the live value. Software that reads several bytes must re-read the low byte to detect a carry that happened between the reads. The pending flag is cleared by a one-shot command bit in its own register.

Top module: `secs_rtc_core`

## Requirements
- R1: After reset, the count, the alarm value, the counter enable, the alarm enable and the pending flag are all zero, and `alarm_irq` is low.
- R2: A write to offset 2 loads the counter with {staged byte 3, staged byte 2, staged byte 1, write data}, in that same cycle. A load takes priority over a tick in the same cycle. After the full sequence (counter off, 0x00 to offset 2, bytes to offsets 3..5, real low byte to offset 2) the count equals exactly the written value.
- R3: Writes to offsets 3, 4 and 5 change only the staging bytes and leave the count unchanged. Staged bytes keep their value across loads. The four offsets 2..5 read as 0x00.
- R4: While the counter enable (bit 7 at offset 0) is clear, ticks leave the count unchanged.
- R5: While the counter enable is set, each `tick_1hz` cycle adds one to the count.
- R6: Offset 0 reads back the counter enable in bit 7 and the alarm enable in bit 1, with all other bits 0, so a read-modify-write keeps bit 7.
- R7: Offsets 6..9 return count bytes 0..3 (offset 6 is least significant) live, with no snapshot: a low byte re-read after a carry tick is smaller than the first read.
- R8: The count wraps from 0xFFFFFFFF to 0x00000000 on a counting tick.
- R9: Offsets 10..13 hold alarm bytes 0..3 (offset 10 least significant) and read back what was written.
- R10: The pending flag sets only on a counting tick that makes the count equal to the alarm value while the alarm enable is set. A load to that value, or a tick while the counter is off, does not set it. Once set, the flag stays set on later ticks, and `alarm_irq` shows the flag.
- R11: Writing a 1 to bit 0 of offset 1 clears the pending flag. Offset 1 always reads as 0x00.
- R12: With the alarm enable clear, reaching the alarm value leaves `alarm_irq` low.
- R13: If a clear command and an alarm-setting tick fall in the same cycle, the flag ends set.
- R14: Read data appears on `bus_rdata` in the cycle after the read strobe and holds until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1hz | input | 1 | One-cycle pulse each second |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_we | input | 1 | Write strobe |
| bus_re | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| alarm_irq | output | 1 | Alarm pending level |

## Verification
The hardest situation to reach is a clear command that lands in the same clock cycle as the tick that matches the alarm. The bench first loads a count one below the alarm value and arms the alarm. It then drives the tick and the clear write together from a single clock edge, and checks that the flag ends set. The carry race is produced in a similar way. The bench reads the low byte, places a tick between that read and the re-read, and expects a smaller value the second time.

// File: rtl/secs_rtc_pkg.sv
package secs_rtc_pkg;
  localparam int unsigned BYTE_W      = 8;
  localparam int unsigned OFS_CTRL    = 0;
  localparam int unsigned OFS_CLR     = 1;
  localparam int unsigned OFS_STAGE   = 2;
  localparam int unsigned BIT_CNT_EN  = 7;
  localparam int unsigned BIT_ALM_EN  = 1;
  localparam int unsigned BIT_CLR     = 0;
endpackage

// File: rtl/secs_rtc_regfile.sv
module secs_rtc_regfile
  import secs_rtc_pkg::*;
#(
  parameter int unsigned NBYTES = 4,
  parameter int unsigned ADDR_W = 4,
  localparam int unsigned CNT_W = BYTE_W * NBYTES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              we,
  input  logic              re,
  input  logic [CNT_W-1:0]  count,
  output logic [BYTE_W-1:0] rdata,
  output logic              cnt_en,
  output logic              alm_en,
  output logic              load,
  output logic [CNT_W-1:0]  load_val,
  output logic [CNT_W-1:0]  alarm_val,
  output logic              clr_req
);
  localparam int unsigned OFS_LIVE = OFS_STAGE + NBYTES;
  localparam int unsigned OFS_ALM  = OFS_LIVE + NBYTES;
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_CLR   = ADDR_W'(OFS_CLR);
  localparam logic [ADDR_W-1:0] A_STAGE = ADDR_W'(OFS_STAGE);

  logic ctrl_wr;
  logic cnt_en_q, cnt_en_d, alm_en_q, alm_en_d;
  logic [CNT_W-1:BYTE_W] stage_q;
  logic [CNT_W-1:0]      alarm_q;
  logic [BYTE_W-1:0]     rd_q, rd_d;

  // control bits
  assign ctrl_wr = we && (addr == A_CTRL);

  always_comb begin
    cnt_en_d = cnt_en_q;
    alm_en_d = alm_en_q;
    if (ctrl_wr) begin
      cnt_en_d = wdata[BIT_CNT_EN];
      alm_en_d = wdata[BIT_ALM_EN];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_en_q <= 1'b0;
      alm_en_q <= 1'b0;
    end else if (ctrl_wr) begin
      cnt_en_q <= cnt_en_d;
      alm_en_q <= alm_en_d;
    end
  end

  // staging bytes 1..NBYTES-1 and alarm bytes, one lane each
  genvar g;
  generate
    for (g = 1; g < NBYTES; g++) begin : g_stage
      logic lane_wr;
      assign lane_wr = we && (addr == ADDR_W'(OFS_STAGE + g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       stage_q[BYTE_W*g +: BYTE_W] <= '0;
        else if (lane_wr) stage_q[BYTE_W*g +: BYTE_W] <= wdata;
      end
    end
    for (g = 0; g < NBYTES; g++) begin : g_alarm
      logic lane_wr;
      assign lane_wr = we && (addr == ADDR_W'(OFS_ALM + g));
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       alarm_q[BYTE_W*g +: BYTE_W] <= '0;
        else if (lane_wr) alarm_q[BYTE_W*g +: BYTE_W] <= wdata;
      end
    end
  endgenerate

  // read path, registered on the strobe
  always_comb begin
    rd_d = '0;
    if (addr == A_CTRL) begin
      rd_d[BIT_CNT_EN] = cnt_en_q;
      rd_d[BIT_ALM_EN] = alm_en_q;
    end
    for (int b = 0; b < NBYTES; b++) begin
      if (addr == ADDR_W'(OFS_LIVE + b)) rd_d = count[BYTE_W*b +: BYTE_W];
      if (addr == ADDR_W'(OFS_ALM + b))  rd_d = alarm_q[BYTE_W*b +: BYTE_W];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  rd_q <= '0;
    else if (re) rd_q <= rd_d;
  end

  assign rdata     = rd_q;
  assign cnt_en    = cnt_en_q;
  assign alm_en    = alm_en_q;
  assign load      = we && (addr == A_STAGE);
  assign load_val  = {stage_q, wdata};
  assign alarm_val = alarm_q;
  assign clr_req   = we && (addr == A_CLR) && wdata[BIT_CLR];
endmodule

// File: rtl/secs_rtc_counter.sv
module secs_rtc_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             cnt_en,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] count_next,
  output logic             step
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             upd;

  assign step = tick && cnt_en && !load;
  assign upd  = load || step;

  always_comb begin
    cnt_d = cnt_q;
    if (load)      cnt_d = load_val;
    else if (step) cnt_d = cnt_q + CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt_q <= '0;
    else if (upd) cnt_q <= cnt_d;
  end

  assign count      = cnt_q;
  assign count_next = cnt_d;
endmodule

// File: rtl/secs_rtc_alarm.sv
module secs_rtc_alarm #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             alm_en,
  input  logic [CNT_W-1:0] count_next,
  input  logic [CNT_W-1:0] alarm_val,
  input  logic             clr_req,
  output logic             pending
);
  logic pend_q, pend_d, hit;

  assign hit = step && alm_en && (count_next == alarm_val);

  // a hit outranks a clear in the same cycle
  always_comb begin
    pend_d = pend_q;
    if (clr_req) pend_d = 1'b0;
    if (hit)     pend_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign pending = pend_q;
endmodule

// File: rtl/secs_rtc_core.sv
module secs_rtc_core
  import secs_rtc_pkg::*;
#(
  parameter int unsigned NBYTES = 4,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_1hz,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [7:0]        bus_wdata,
  input  logic              bus_we,
  input  logic              bus_re,
  output logic [7:0]        bus_rdata,
  output logic              alarm_irq
);
  localparam int unsigned CNT_W = BYTE_W * NBYTES;

  logic             cnt_en, alm_en, load, clr_req, step;
  logic [CNT_W-1:0] load_val, alarm_val, count_q, count_next;

  secs_rtc_regfile #(.NBYTES(NBYTES), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .addr(bus_addr), .wdata(bus_wdata),
    .we(bus_we), .re(bus_re), .count(count_q), .rdata(bus_rdata),
    .cnt_en(cnt_en), .alm_en(alm_en), .load(load), .load_val(load_val),
    .alarm_val(alarm_val), .clr_req(clr_req)
  );

  secs_rtc_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(tick_1hz), .cnt_en(cnt_en),
    .load(load), .load_val(load_val), .count(count_q),
    .count_next(count_next), .step(step)
  );

  secs_rtc_alarm #(.CNT_W(CNT_W)) u_alm (
    .clk(clk), .rst_n(rst_n), .step(step), .alm_en(alm_en),
    .count_next(count_next), .alarm_val(alarm_val), .clr_req(clr_req),
    .pending(alarm_irq)
  );
endmodule

// File: rtl/secs_rtc_checks.sv
module secs_rtc_checks #(
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned ADDR_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              tick_1hz,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [7:0]        bus_wdata,
  input logic              bus_we,
  input logic              bus_re,
  input logic [7:0]        bus_rdata,
  input logic              alarm_irq,
  input logic              cnt_en,
  input logic              alm_en,
  input logic [CNT_W-1:0]  count_q,
  input logic [CNT_W-1:0]  load_val,
  input logic [CNT_W-1:0]  alarm_val
);
  logic wr_stage, wr_clr;
  assign wr_stage = bus_we && (bus_addr == ADDR_W'(2));
  assign wr_clr   = bus_we && (bus_addr == ADDR_W'(1)) && bus_wdata[0];

  p_commit_r2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stage |=> count_q == $past(load_val));

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_en && !wr_stage) |=> $stable(count_q));

  p_inc_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_en && tick_1hz && !wr_stage) |=> count_q == $past(count_q) + CNT_W'(1));

  p_irq_needs_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(alarm_irq) |-> $past(tick_1hz && cnt_en && alm_en));

  p_clear_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && !tick_1hz) |=> !alarm_irq);

  p_clear_readback_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_re && bus_addr == ADDR_W'(1)) |=> bus_rdata == 8'h00);

  p_set_wins_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_clr && tick_1hz && cnt_en && alm_en && !wr_stage &&
     (count_q + CNT_W'(1) == alarm_val)) |=> alarm_irq);

  p_rdata_hold_r14: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_re |=> $stable(bus_rdata));
endmodule

bind secs_rtc_core secs_rtc_checks #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_checks (
  .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .bus_addr(bus_addr),
  .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
  .bus_rdata(bus_rdata), .alarm_irq(alarm_irq), .cnt_en(cnt_en),
  .alm_en(alm_en), .count_q(count_q), .load_val(load_val),
  .alarm_val(alarm_val)
);

// File: tb/secs_rtc_core_test.sv
`timescale 1ns/1ps
module secs_rtc_core_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       tick_1hz;
  logic [3:0] bus_addr;
  logic [7:0] bus_wdata;
  logic       bus_we, bus_re;
  logic [7:0] bus_rdata;
  logic       alarm_irq;

  int total = 0;
  int bad   = 0;
  bit done  = 1'b0;

  logic [7:0] exp_q[$];
  string      tag_q[$];

  always #2 clk = ~clk;

  secs_rtc_core uut (
    .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_we(bus_we), .bus_re(bus_re),
    .bus_rdata(bus_rdata), .alarm_irq(alarm_irq)
  );

  // monitor: one expected byte per read strobe, compared a half cycle after the edge
  initial begin
    forever begin
      @(posedge clk);
      if (bus_re) begin
        @(negedge clk);
        if (exp_q.size() != 0) begin
          logic [7:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          total++;
          if (bus_rdata !== e) begin
            bad++;
            $display("FAIL %s: rdata=%02h expected=%02h", t, bus_rdata, e);
          end
        end
      end
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [3:0] a, input logic [7:0] e, input string t);
    @(negedge clk);
    exp_q.push_back(e);
    tag_q.push_back(t);
    bus_addr = a; bus_re = 1'b1;
    @(negedge clk);
    bus_re = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    tick_1hz = 1'b1;
    @(negedge clk);
    tick_1hz = 1'b0;
  endtask

  task automatic load32(input logic [31:0] v);
    wr(4'd2, 8'h00);
    wr(4'd3, v[15:8]);
    wr(4'd4, v[23:16]);
    wr(4'd5, v[31:24]);
    wr(4'd2, v[7:0]);
  endtask

  task automatic rd32(input logic [31:0] e, input string t);
    for (int b = 0; b < 4; b++) rd(4'(6 + b), e[8*b +: 8], t);
  endtask

  task automatic chk_irq(input logic e, input string t);
    total++;
    if (alarm_irq !== e) begin
      bad++;
      $display("FAIL %s: alarm_irq=%0b expected=%0b", t, alarm_irq, e);
    end
  endtask

  task automatic drain();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; tick_1hz = 1'b0; bus_addr = '0; bus_wdata = '0;
    bus_we = 1'b0; bus_re = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    chk_irq(1'b0, "R1 irq after reset");
    rd(4'd0, 8'h00, "R1 ctrl");
    rd32(32'h0, "R1 count");
    for (int b = 0; b < 4; b++) rd(4'(10 + b), 8'h00, "R1 alarm");

    // R2: full load sequence, counter off
    wr(4'd0, 8'h00);
    load32(32'h56341278);
    rd32(32'h56341278, "R2 load value");

    // R3: staging only, then commit with retained staged bytes
    wr(4'd5, 8'hAA);
    rd(4'd9, 8'h56, "R3 staged byte not live");
    rd(4'd5, 8'h00, "R3 staging reads zero");
    rd(4'd2, 8'h00, "R3 low staging reads zero");
    wr(4'd2, 8'h00);
    rd32(32'hAA341200, "R3 commit uses staged bytes");

    // R4: ticks ignored while counter off
    tick(); tick();
    rd32(32'hAA341200, "R4 hold while disabled");

    // R6: control readback
    wr(4'd0, 8'hFF);
    rd(4'd0, 8'h82, "R6 ctrl readback set");
    wr(4'd0, 8'h7D);
    rd(4'd0, 8'h00, "R6 ctrl readback clear");

    // R5: increment while enabled
    wr(4'd0, 8'h00);
    load32(32'h00000010);
    wr(4'd0, 8'h80);
    tick(); tick(); tick();
    rd32(32'h00000013, "R5 three ticks");

    // R7: live read exposes carry
    wr(4'd0, 8'h00);
    load32(32'h000001FF);
    wr(4'd0, 8'h80);
    rd(4'd6, 8'hFF, "R7 first low byte");
    tick();
    rd(4'd6, 8'h00, "R7 re-read low byte smaller");
    rd(4'd7, 8'h02, "R7 carry into byte1");

    // R8: wrap
    wr(4'd0, 8'h00);
    load32(32'hFFFFFFFF);
    wr(4'd0, 8'h80);
    tick();
    rd32(32'h00000000, "R8 wrap to zero");

    // R9: alarm bytes read back
    wr(4'd10, 8'h02); wr(4'd11, 8'h01); wr(4'd12, 8'h00); wr(4'd13, 8'h00);
    for (int b = 0; b < 4; b++) rd(4'(10 + b), (b == 0) ? 8'h02 : (b == 1) ? 8'h01 : 8'h00, "R9 alarm readback");

    // R10: alarm fires on matching tick and is sticky
    wr(4'd0, 8'h00);
    load32(32'h00000100);
    wr(4'd0, 8'h82);
    tick();
    chk_irq(1'b0, "R10 no fire before match");
    tick();
    chk_irq(1'b1, "R10 fire on match");
    tick();
    chk_irq(1'b1, "R10 sticky after match");

    // R11: clear command
    wr(4'd1, 8'h01);
    chk_irq(1'b0, "R11 cleared");
    rd(4'd1, 8'h00, "R11 clear reads zero");

    // R10: load to alarm value or tick while counter off does not fire
    wr(4'd0, 8'h02);
    load32(32'h00000102);
    chk_irq(1'b0, "R10 load does not fire");
    load32(32'h00000101);
    tick();
    chk_irq(1'b0, "R10 no fire while counter off");

    // R12: alarm enable clear
    wr(4'd0, 8'h80);
    tick();
    rd32(32'h00000102, "R12 count reached alarm");
    chk_irq(1'b0, "R12 no fire when alarm disabled");

    // R13: clear and hit in the same cycle
    wr(4'd0, 8'h00);
    load32(32'h00000101);
    wr(4'd0, 8'h82);
    @(negedge clk);
    tick_1hz = 1'b1; bus_addr = 4'd1; bus_wdata = 8'h01; bus_we = 1'b1;
    @(negedge clk);
    tick_1hz = 1'b0; bus_we = 1'b0;
    chk_irq(1'b1, "R13 hit outranks clear");

    // R14: read data holds without a strobe
    rd(4'd0, 8'h82, "R14 read value");
    wr(4'd0, 8'h00);
    repeat (3) @(negedge clk);
    total++;
    if (bus_rdata !== 8'h82) begin
      bad++;
      $display("FAIL R14 hold: rdata=%02h expected=82", bus_rdata);
    end

    drain();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run incomplete, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule